// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the next memory level. It absorbs CPU stores at once, so the processor never waits on the slower memory. Each buffered entry covers one aligned block of four 32-bit words and keeps a separate valid flag per word. A store whose block is already buffered, in an entry that memory has not yet been offered, is folded into that entry. A run of stores to neighbouring words therefore becomes a single block write instead of four.

Entries leave in the order they were created. Each one is presented to memory as a block-aligned address, four data words and a 4-bit word mask. Memory takes it on a valid/ready handshake. The cache watches `full` to stall a store that cannot be placed. It watches `empty` to learn that every pending write has reached memory.

Top module: `merge_wbuf`

## Requirements
- R1: After reset `empty` is 1, `full` is 0, `mem_valid` is 0 and `st_ready` is 1.
- R2: A store that matches no mergeable entry allocates a new entry whose mask has only the bit for its word set. Mask bit i stands for the word at byte offset 4*i in the block, and i is address bits [3:2].
- R3: Four stores to the four words of one block, arriving while that entry is not offered to memory, end in one entry with mask 4'b1111. That entry is drained as one transaction.
- R4: A store to a word whose mask bit is already set replaces that word's data in the same entry.
- R5: Entries drain oldest first. A transfer happens on a cycle with `mem_valid` and `mem_ready` both high. `mem_addr` is the block address with bits [3:0] zero. Word i sits on `mem_data[32*i+31:32*i]`, and `mem_mask` carries the entry's mask.
- R6: Once an entry is offered, `mem_addr`, `mem_data` and `mem_mask` hold steady until the transfer. The entry takes no further merges, and a store to its block allocates a new entry.
- R7: The oldest entry is offered when any of these holds: more than one entry is pending, it was already offered, or no store is presented that cycle.
- R8: With all DEPTH entries in use, `full` is 1. A store matching no mergeable entry then sees `st_ready` low and is not taken, even if a drain completes that cycle. A store that merges is still taken.
- R9: `empty` is 1 exactly when no entry is pending, and `mem_valid` is then 0.
- R10: Stores are accepted regardless of `mem_ready`; `st_ready` is 1 whenever `full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store presented |
| st_addr | input | 32 | Store byte address (word aligned) |
| st_data | input | 32 | Store data word |
| st_ready | output | 1 | Store taken this cycle when high with st_valid |
| mem_valid | output | 1 | Oldest entry offered to memory |
| mem_ready | input | 1 | Memory accepts the offered block |
| mem_addr | output | 32 | Block-aligned address of the offered entry |
| mem_data | output | 128 | Four data words, word i at bits 32*i+31:32*i |
| mem_mask | output | 4 | Per-word valid mask |
| full | output | 1 | All entries in use |
| empty | output | 1 | No pending write |

## Verification
The bench keeps an independent model of entries, masks and the offer rule. It replays a burst of stores against that model with memory stalled, then drains and compares every block. The burst covers the four-word merge, an overwrite of a valid word, and a store to the block of an already-offered entry. A design that merged into the offered entry would lose or alter data already on the bus, and the drained blocks would not match. A full buffer is hit with both a non-matching and a merging store: refusing the merge would stall needlessly, and taking the other store would overwrite a live entry. A drain coinciding with a rejected store checks that capacity freed in the same cycle is not used early.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int WB_ADDR_W = 32;
    localparam int WB_DATA_W = 32;
    localparam int WB_SLOTS  = 4;
    localparam int SLOT_W    = $clog2(WB_SLOTS);
    localparam int WORD_LSB  = $clog2(WB_DATA_W / 8);
    localparam int BLK_LSB   = WORD_LSB + SLOT_W;
    localparam int BLK_W     = WB_ADDR_W - BLK_LSB;

    typedef struct packed {
        logic [BLK_W-1:0]                       blk;
        logic [WB_SLOTS-1:0]                    mask;
        logic [WB_SLOTS-1:0][WB_DATA_W-1:0]     data;
    } wb_entry_t;

    function automatic logic [BLK_W-1:0] blk_of(input logic [WB_ADDR_W-1:0] a);
        return a[WB_ADDR_W-1:BLK_LSB];
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic [WB_ADDR_W-1:0] a);
        return a[BLK_LSB-1:WORD_LSB];
    endfunction
endpackage

// File: rtl/wbuf_ptrs.sv
module wbuf_ptrs #(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic [PTR_W:0]   count,
    output logic [DEPTH-1:0] occ
);
    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= tail + 1'b1;
            if (pop)  head <= head + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_occ
        logic [PTR_W-1:0] rel;
        assign rel    = PTR_W'(i) - head;
        assign occ[i] = {1'b0, rel} < count;
    end
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match import wbuf_pkg::*; #(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            cand,
    input  logic [DEPTH-1:0][BLK_W-1:0] blk_vec,
    input  logic [BLK_W-1:0]            st_blk,
    output logic                        hit,
    output logic [PTR_W-1:0]            hit_idx
);
    logic [DEPTH-1:0] eq;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign eq[i] = cand[i] && (blk_vec[i] == st_blk);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_idx = PTR_W'(i);
            end
        end
    end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf import wbuf_pkg::*; #(
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          st_valid,
    input  logic [WB_ADDR_W-1:0]          st_addr,
    input  logic [WB_DATA_W-1:0]          st_data,
    output logic                          st_ready,
    output logic                          mem_valid,
    input  logic                          mem_ready,
    output logic [WB_ADDR_W-1:0]          mem_addr,
    output logic [WB_SLOTS*WB_DATA_W-1:0] mem_data,
    output logic [WB_SLOTS-1:0]           mem_mask,
    output logic                          full,
    output logic                          empty
);
    localparam int PTR_W = $clog2(DEPTH);

    wb_entry_t                   ent_q [DEPTH];
    logic                        head_lock_q;
    logic [PTR_W-1:0]            head, tail, hit_idx;
    logic [PTR_W:0]              count;
    logic [DEPTH-1:0]            occ, cand;
    logic [DEPTH-1:0][BLK_W-1:0] blk_vec;
    logic                        hit, offer, accept, alloc, pop;
    logic [BLK_W-1:0]            st_blk;
    logic [SLOT_W-1:0]           slot;

    assign st_blk = blk_of(st_addr);
    assign slot   = slot_of(st_addr);
    assign empty  = (count == '0);
    assign full   = (count == (PTR_W+1)'(DEPTH));

    // Oldest entry goes out once it can no longer gain merges cheaply.
    assign offer = !empty && (head_lock_q || count > (PTR_W+1)'(1) || !st_valid);

    for (genvar i = 0; i < DEPTH; i++) begin : g_cand
        assign blk_vec[i] = ent_q[i].blk;
        assign cand[i]    = occ[i] && !(offer && head == PTR_W'(i));
    end

    wbuf_match #(.DEPTH(DEPTH)) u_match (
        .cand    (cand),
        .blk_vec (blk_vec),
        .st_blk  (st_blk),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    assign st_ready = hit || !full;
    assign accept   = st_valid && st_ready;
    assign alloc    = accept && !hit;
    assign pop      = offer && mem_ready;

    wbuf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .rst   (rst),
        .push  (alloc),
        .pop   (pop),
        .head  (head),
        .tail  (tail),
        .count (count),
        .occ   (occ)
    );

    always_ff @(posedge clk) begin
        if (rst)       head_lock_q <= 1'b0;
        else if (pop)  head_lock_q <= 1'b0;
        else if (offer) head_lock_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (accept) begin
            if (hit) begin
                ent_q[hit_idx].mask[slot] <= 1'b1;
                ent_q[hit_idx].data[slot] <= st_data;
            end else begin
                ent_q[tail].blk        <= st_blk;
                ent_q[tail].mask       <= WB_SLOTS'(1) << slot;
                ent_q[tail].data[slot] <= st_data;
            end
        end
    end

    assign mem_valid = offer;
    assign mem_addr  = {ent_q[head].blk, {BLK_LSB{1'b0}}};
    assign mem_data  = ent_q[head].data;
    assign mem_mask  = ent_q[head].mask;
endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker import wbuf_pkg::*; (
    input logic                          clk,
    input logic                          rst,
    input logic                          st_ready,
    input logic                          mem_valid,
    input logic                          mem_ready,
    input logic [WB_ADDR_W-1:0]          mem_addr,
    input logic [WB_SLOTS*WB_DATA_W-1:0] mem_data,
    input logic [WB_SLOTS-1:0]           mem_mask,
    input logic                          full,
    input logic                          empty
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (empty && !full && !mem_valid));

    assert_mask_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_mask != '0));

    assert_addr_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[BLK_LSB-1:0] == '0));

    assert_offer_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_mask) && $stable(mem_data)));

    assert_full_not_empty_R8: assert property (@(posedge clk) disable iff (rst)
        full |-> !empty);

    assert_empty_idle_R9: assert property (@(posedge clk) disable iff (rst)
        empty |-> !mem_valid);

    assert_no_wait_R10: assert property (@(posedge clk) disable iff (rst)
        !full |-> st_ready);
endmodule

bind merge_wbuf wbuf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .st_ready  (st_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_mask  (mem_mask),
    .full      (full),
    .empty     (empty)
);

// File: tb/sim_merge_wbuf.sv
`timescale 1ns/1ps
module sim_merge_wbuf;
    localparam int DEPTH = 4;
    localparam int NVEC  = 12;

    // {expected st_ready, address, data}
    localparam logic [64:0] VEC [NVEC] = '{
        {1'b1, 32'h0000_0100, 32'hA000_0000},
        {1'b1, 32'h0000_0104, 32'hA000_0001},
        {1'b1, 32'h0000_0108, 32'hA000_0002},
        {1'b1, 32'h0000_010C, 32'hA000_0003},
        {1'b1, 32'h0000_0200, 32'hB000_0000},
        {1'b1, 32'h0000_0104, 32'hC000_0001},
        {1'b1, 32'h0000_0208, 32'hB000_0002},
        {1'b1, 32'h0000_0200, 32'hB111_0000},
        {1'b1, 32'h0000_0300, 32'hD000_0000},
        {1'b0, 32'h0000_0510, 32'hE000_0000},
        {1'b1, 32'h0000_030C, 32'hD000_0003},
        {1'b1, 32'h0000_0204, 32'hB000_0001}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         st_valid = 1'b0;
    logic [31:0]  st_addr = '0;
    logic [31:0]  st_data = '0;
    logic         st_ready;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic [31:0]  mem_addr;
    logic [127:0] mem_data;
    logic [3:0]   mem_mask;
    logic         full, empty;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // bench model of pending entries, oldest at index 0
    logic [27:0] m_blk  [8];
    logic [3:0]  m_mask [8];
    logic [31:0] m_data [8][4];
    int          m_cnt  = 0;
    bit          m_lock = 1'b0;

    always #4 clk = ~clk;

    merge_wbuf #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_ready(st_ready), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_mask(mem_mask), .full(full), .empty(empty)
    );

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic check_head(input string tag);
        check({tag, " addr"}, 128'(mem_addr), 128'({m_blk[0], 4'h0}));
        check({tag, " mask"}, 128'(mem_mask), 128'(m_mask[0]));
        for (int s = 0; s < 4; s++)
            if (m_mask[0][s])
                check({tag, " data"}, 128'(mem_data[32*s +: 32]), 128'(m_data[0][s]));
    endtask

    task automatic m_pop();
        for (int k = 0; k < m_cnt - 1; k++) begin
            m_blk[k]  = m_blk[k+1];
            m_mask[k] = m_mask[k+1];
            for (int s = 0; s < 4; s++) m_data[k][s] = m_data[k+1][s];
        end
        m_cnt--;
        m_lock = 1'b0;
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic rdy,
                            output logic exp_rdy);
        bit offer;
        int hit;
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; mem_ready = rdy;
        #1;
        offer = (m_cnt > 0) && (m_lock || m_cnt > 1);
        hit = -1;
        for (int j = (offer ? 1 : 0); j < m_cnt; j++)
            if (m_blk[j] == a[31:4]) hit = j;
        exp_rdy = (hit >= 0) || (m_cnt < DEPTH);
        check("R8 st_ready", 128'(st_ready), 128'(exp_rdy));
        check("R8 full", 128'(full), 128'(m_cnt == DEPTH));
        check("R7 offer", 128'(mem_valid), 128'(offer));
        if (offer && rdy) check_head("R5 drain");
        if (exp_rdy) begin
            if (hit >= 0) begin
                m_mask[hit][a[3:2]] = 1'b1;
                m_data[hit][a[3:2]] = d;
            end else begin
                m_blk[m_cnt]  = a[31:4];
                m_mask[m_cnt] = 4'b0001 << a[3:2];
                m_data[m_cnt][a[3:2]] = d;
                m_cnt++;
            end
        end
        if (offer) m_lock = 1'b1;
        if (offer && rdy) m_pop();
    endtask

    task automatic do_idle(input logic rdy);
        bit offer;
        @(negedge clk);
        st_valid = 1'b0; mem_ready = rdy;
        #1;
        offer = (m_cnt > 0);
        check("R7 idle offer", 128'(mem_valid), 128'(offer));
        check("R9 empty", 128'(empty), 128'(m_cnt == 0));
        if (offer) check_head("R4 R5 head");
        if (offer) m_lock = 1'b1;
        if (offer && rdy) m_pop();
    endtask

    task automatic drain_all();
        while (m_cnt > 0) do_idle(1'b1);
        do_idle(1'b0);
        check("R9 empty after drain", 128'(empty), 128'(1));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 empty", 128'(empty), 128'(1));
        check("R1 full", 128'(full), 128'(0));
        check("R1 mem_valid", 128'(mem_valid), 128'(0));
        check("R1 st_ready", 128'(st_ready), 128'(1));

        // table: back-to-back stores with memory stalled (R10)
        for (int v = 0; v < NVEC; v++) begin
            do_store(VEC[v][63:32], VEC[v][31:0], 1'b0, r);
            check("R10 table st_ready", 128'(st_ready), 128'(VEC[v][64]));
        end
        do_idle(1'b0);
        check("R3 merged mask", 128'(mem_mask), 128'(4'hF));
        check("R3 block addr", 128'(mem_addr), 128'(32'h100));
        drain_all();

        // R2 single store, then idle cycle offers it (R7)
        do_store(32'h0000_500C, 32'h1234_5678, 1'b0, r);
        do_idle(1'b0);
        check("R2 one-hot mask", 128'(mem_mask), 128'(4'b1000));
        drain_all();

        // R6 store to the block of an offered entry allocates anew
        do_store(32'h0000_4008, 32'h0000_4008, 1'b0, r);
        do_idle(1'b0);
        do_store(32'h0000_4000, 32'h0000_4000, 1'b0, r);
        #1;
        check("R6 offered mask held", 128'(mem_mask), 128'(4'b0100));
        check("R6 second entry", 128'(m_cnt), 128'(2));
        check("R6 not empty", 128'(empty), 128'(0));
        drain_all();

        // R8 full buffer: drain in the same cycle does not admit a new block
        for (int k = 0; k < DEPTH; k++)
            do_store(32'h0000_9000 + 32'(k) * 32'h100, 32'(k), 1'b0, r);
        do_store(32'h0000_A000, 32'hAAAA_0000, 1'b1, r);
        check("R8 rejected while full", 128'(r), 128'(0));
        do_store(32'h0000_A000, 32'hAAAA_0000, 1'b0, r);
        check("R8 accepted after drain", 128'(r), 128'(1));
        drain_all();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule